// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `W` bits one bit position per clock. It uses a single full adder and a one-bit carry register for every position instead of a `W`-bit parallel adder. Both operands sit in right-shifting registers. On every shift, the full adder combines the least significant bit of each register with the stored carry. The sum bit re-enters the accumulator register at its most significant end, and the new carry goes back into the carry register. After `W` shifts, the accumulator holds the sum least significant bit first, fully realigned. The carry register then holds the final carry-out.

To use it, a controller loads both operands in parallel and pulses the carry clear. It then holds the shift enable high. A bit counter stops the shifting after exactly `W` shifts and raises a done flag. The flag stays high until the next load. The second operand register fills from an external serial line as it empties, so a following operand can be streamed in while the current one is consumed.

Top module: `bitser_adder`

## Requirements
- R1: While reset is high, and on the cycle after it, the accumulator, the second operand register, the carry and `done` are all zero.
- R2: A cycle with `load` high puts `a_in` on `a_out` and `b_in` on `b_out` one cycle later. It also clears `done` and restarts the shift count. `load` takes priority over shifting.
- R3: A shift makes the new `a_out[W-1]` equal to the XOR of the old `a_out[0]`, `b_out[0]` and `carry_q`. It also moves every other accumulator bit one position toward bit 0.
- R4: A shift without `carry_clr` loads `carry_q` with the majority of the old `a_out[0]`, `b_out[0]` and `carry_q`.
- R5: `carry_clr` forces `carry_q` to 0 on the next cycle, even during a shift. The shift in that cycle still uses the old carry for its sum bit.
- R6: A shift moves the second operand register one position toward bit 0, and `ser_in` enters its bit `W-1`.
- R7: `done` rises exactly on the cycle after the `W`-th shift since the last load or reset. It stays high until the next load.
- R8: When `shift_en` is low or `done` is high, and `load` is low, `a_out` and `b_out` keep their values. `carry_q` also keeps its value unless `carry_clr` is high.
- R9: After a load, a carry clear and `W` shifts, `a_out` holds the sum of the loaded operands modulo 2^W and `carry_q` holds its carry-out. For example, 0x04 + 0x07 gives 0x0B with carries 0, 0, 1, 0 after the first four shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load of both operand registers |
| a_in | input | W | Accumulator load value |
| b_in | input | W | Second operand load value |
| shift_en | input | 1 | Allows one shift per clock until done |
| carry_clr | input | 1 | Clears the carry register |
| ser_in | input | 1 | Serial input into the second operand register |
| a_out | output | W | Accumulator contents (sum after completion) |
| b_out | output | W | Second operand register contents |
| carry_q | output | 1 | Stored carry |
| done | output | 1 | High once W shifts have completed |

## Verification
The checker evaluates these rules every cycle:
- the per-shift rules for the sum bit, the carry update, the right shift of both registers and the serial entry;
- load capture and carry clearing;
- the freezing of both registers while idle or done;
- the match between `done` and an independent count of shifts.

Only the bench scenarios show that these steps add up to a correct sum. They cover a full-word result, the final carry-out, a pause in the middle of an addition, a clear in the middle of an addition, and the worked example's intermediate carries.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;
endpackage

// File: rtl/bitser_fa.sv
module bitser_fa (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);
  always_comb begin
    sum  = x ^ y ^ cin;
    cout = (x & y) | (x & cin) | (y & cin);
  end
endmodule

// File: rtl/bitser_carry.sv
module bitser_carry (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (upd)   q <= d;
  end
endmodule

// File: rtl/bitser_shreg.sv
module bitser_shreg
  import bitser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  act_e         act,
  input  logic [W-1:0] par_in,
  input  logic         ser_bit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (act)
        ACT_LOAD:  q <= par_in;
        ACT_SHIFT: q <= {ser_bit, q[W-1:1]};
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
  import bitser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic shift_en,
  output act_e act,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    if (load)                  act = ACT_LOAD;
    else if (shift_en && !done) act = ACT_SHIFT;
    else                       act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (act == ACT_LOAD) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (act == ACT_SHIFT) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/bitser_adder.sv
module bitser_adder
  import bitser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         shift_en,
  input  logic         carry_clr,
  input  logic         ser_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         carry_q,
  output logic         done
);
  act_e act;
  logic fa_sum;
  logic fa_cout;

  bitser_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .shift_en (shift_en),
    .act      (act),
    .done     (done)
  );

  bitser_fa u_fa (
    .x    (a_out[0]),
    .y    (b_out[0]),
    .cin  (carry_q),
    .sum  (fa_sum),
    .cout (fa_cout)
  );

  bitser_carry u_carry (
    .clk (clk),
    .rst (rst),
    .clr (carry_clr),
    .upd (act == ACT_SHIFT),
    .d   (fa_cout),
    .q   (carry_q)
  );

  bitser_shreg #(.W(W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .par_in  (a_in),
    .ser_bit (fa_sum),
    .q       (a_out)
  );

  bitser_shreg #(.W(W)) u_opb (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .par_in  (b_in),
    .ser_bit (ser_in),
    .q       (b_out)
  );
endmodule

// File: rtl/bitser_adder_chk.sv
module bitser_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         shift_en,
  input logic         carry_clr,
  input logic         ser_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         carry_q,
  input logic         done
);
  localparam int CW = $clog2(W + 1);

  logic          fire;
  logic [CW-1:0] seen;

  assign fire = shift_en && !done && !load;

  always_ff @(posedge clk) begin
    if (rst || load) seen <= '0;
    else if (fire)   seen <= seen + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && !carry_q && !done));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (a_out == $past(a_in) && b_out == $past(b_in) && !done));

  assert_sum_bit_R3: assert property (@(posedge clk) disable iff (rst)
    fire |=> (a_out[W-1] == ($past(a_out[0]) ^ $past(b_out[0]) ^ $past(carry_q))
              && a_out[W-2:0] == $past(a_out[W-1:1])));

  assert_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && !carry_clr) |=> carry_q == (($past(a_out[0]) & $past(b_out[0])) |
                                         ($past(a_out[0]) & $past(carry_q)) |
                                         ($past(b_out[0]) & $past(carry_q))));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    carry_clr |=> !carry_q);

  assert_opb_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (b_out[W-1] == $past(ser_in) && b_out[W-2:0] == $past(b_out[W-1:1])));

  assert_done_R7: assert property (@(posedge clk) disable iff (rst)
    done == (seen == CW'(W)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && (!shift_en || done)) |=> ($stable(a_out) && $stable(b_out)));

  assert_hold_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !carry_clr && (!shift_en || done)) |=> $stable(carry_q));
endmodule

bind bitser_adder bitser_adder_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .a_in      (a_in),
  .b_in      (b_in),
  .shift_en  (shift_en),
  .carry_clr (carry_clr),
  .ser_in    (ser_in),
  .a_out     (a_out),
  .b_out     (b_out),
  .carry_q   (carry_q),
  .done      (done)
);

// File: tb/test_bitser_adder.sv
module test_bitser_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         shift_en = 1'b0;
  logic         carry_clr = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] a_out;
  logic [W-1:0] b_out;
  logic         carry_q;
  logic         done;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_a, m_b, m_c, m_n, m_done;

  always #10 clk = ~clk;

  bitser_adder #(.W(W)) i_bitser_adder (
    .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
    .shift_en(shift_en), .carry_clr(carry_clr), .ser_in(ser_in),
    .a_out(a_out), .b_out(b_out), .carry_q(carry_q), .done(done)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_a <= 0; m_b <= 0; m_c <= 0; m_n <= 0; m_done <= 0;
    end else if (load) begin
      m_a <= int'(a_in); m_b <= int'(b_in); m_n <= 0; m_done <= 0;
      if (carry_clr) m_c <= 0;
    end else begin
      if (shift_en && m_done == 0) begin
        int s;
        s = (m_a % 2) + (m_b % 2) + m_c;
        m_a <= (m_a / 2) + ((s % 2) << (W - 1));
        m_b <= (m_b / 2) + (int'(ser_in) << (W - 1));
        m_c <= carry_clr ? 0 : s / 2;
        m_n <= m_n + 1;
        if (m_n + 1 == W) m_done <= 1;
      end else if (carry_clr) begin
        m_c <= 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 model a_out", int'(a_out), m_a);
      check("R6 model b_out", int'(b_out), m_b);
      check("R4 model carry", int'(carry_q), m_c);
      check("R7 model done", int'(done), m_done);
    end
  end

  task automatic cyc(input logic ld, input logic se, input logic cc, input logic si);
    load = ld; shift_en = se; carry_clr = cc; ser_in = si;
    @(negedge clk);
  endtask

  task automatic start(input int a, input int b);
    a_in = W'(a); b_in = W'(b);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic run_add(input int a, input int b, input logic clr);
    load = 1'b1; a_in = W'(a); b_in = W'(b); carry_clr = clr; shift_en = 1'b0;
    @(negedge clk);
    load = 1'b0; carry_clr = 1'b0;
    for (int k = 0; k < W; k++) cyc(1'b0, 1'b1, 1'b0, 1'($urandom));
    shift_en = 1'b0;
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset a_out", int'(a_out), 0);
    check("R1 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset carry", int'(carry_q), 0);

    // worked example 0x04 + 0x07, ser_in held high
    start(4, 7);
    check("R2 load a_out", int'(a_out), 4);
    check("R2 load b_out", int'(b_out), 7);
    cyc(1'b0, 1'b1, 1'b0, 1'b1); check("R4 carry step1", int'(carry_q), 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1); check("R4 carry step2", int'(carry_q), 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1); check("R4 carry step3", int'(carry_q), 1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1); check("R4 carry step4", int'(carry_q), 0);
    for (int k = 4; k < W - 1; k++) cyc(1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 done not before W shifts", int'(done), 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 done after W shifts", int'(done), 1);
    check("R9 example sum", int'(a_out), 'h0B);
    check("R9 example carry-out", int'(carry_q), 0);
    check("R6 serial fill of b", int'(b_out), 'hFF);
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 frozen when done a_out", int'(a_out), 'h0B);
    check("R8 frozen when done b_out", int'(b_out), 'hFF);

    // carry-out and pause in the middle
    start('hFF, 'h01);
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 pause a_out", int'(a_out), 'h1F);
    check("R8 pause carry", int'(carry_q), 1);
    for (int k = 3; k < W; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 wrap sum", int'(a_out), 0);
    check("R9 wrap carry-out", int'(carry_q), 1);

    // load wins over shift
    a_in = 8'h5A; b_in = 8'h33;
    cyc(1'b1, 1'b1, 1'b0, 1'b1);
    check("R2 load priority a_out", int'(a_out), 'h5A);
    check("R2 load clears done", int'(done), 0);

    // clear during a shift
    start(1, 1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check("R4 carry after 1+1", int'(carry_q), 1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 clear during shift", int'(carry_q), 0);
    check("R5 old carry used in sum", int'(a_out[W-1]), 1);
    shift_en = 1'b0;

    // random additions
    for (int t = 0; t < 24; t++) begin
      int a, b;
      a = int'($urandom_range(0, (1 << W) - 1));
      b = int'($urandom_range(0, (1 << W) - 1));
      run_add(a, b, 1'b1);
      @(negedge clk);
      check("R9 random sum", int'(a_out), (a + b) % (1 << W));
      check("R9 random carry-out", int'(carry_q), (a + b) >> W);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule